// File: doc/BRIEF.md
# External Memory Strobe and Address Translator

This block sits between a processor core and its external memory port. For each accepted request it takes a 24-bit logical word address, an access kind (instruction fetch, program-bus data, data-bus data or I/O), a logical word width and the physical bus width. It classifies the address as on-chip, boot ROM or off-chip. For off-chip addresses it selects one of four active-low bank strobes, or the boot-memory strobe when an override applies. It also scales the logical address into a 22-bit physical byte or halfword address.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both high. The strobe, address and region outputs appear from the next edge and hold until `done_i` is seen. While an access is held, `req_ready_o` is low. A requester that is back-pressured must keep `req_valid_i` and all request fields steady until acceptance. Requests offered while the block is busy are ignored.

Top module: `ext_strobe_xlate`

## Requirements
- R1: A non-I/O access whose address bits 23:16 equal 0x00 raises `on_chip_o`, drives no strobe low, and gives `paddr_o` = 0.
- R2: A non-I/O access whose address bits 23:16 equal 0xFF raises `boot_rom_o`, drives no strobe low, and gives `paddr_o` = 0.
- R3: A non-I/O access to any other page raises `off_chip_o` and drives low bank strobe `bank_stb_no[n]`, where n is address bits 23:22, unless R6 applies.
- R4: The off-chip physical address is the logical address times a factor. With an 8-bit bus (`bus8_i`=1) the factor is 2 for 16-bit words and 4 for 24-bit words. With a 16-bit bus it is 1 for 16-bit words and 2 for 24-bit words.
- R5: Only 22 address lines exist, so the scaled address is truncated modulo 2^22. For example, 0x40FFFF at 16-bit on an 8-bit bus gives 0x01FFFE, and 0x408000 at 24-bit on an 8-bit bus gives 0x020000.
- R6: `bootovr_i` bit 0 applies to fetch, bit 1 to program-bus data and bit 2 to data-bus data. When the bit for the current kind is set and the address lies in 0x010000..0xEFFFFF, the boot strobe is driven low instead of the bank strobe.
- R7: When `dfmt24_i` is set, program-bus data and data-bus data accesses use the 24-bit factor whatever `wide24_i` says. Fetches use `wide24_i` only.
- R8: An I/O access (`acc_i`=3) drives no strobe, raises no region flag and gives `paddr_o` = 0. Kind codes are 0 fetch, 1 program-bus data, 2 data-bus data, 3 I/O.
- R9: A request is accepted only when valid and ready are both high. `req_ready_o` falls the cycle after acceptance, and a request offered while busy has no effect on the outputs.
- R10: The outputs hold steady until `done_i`. The cycle after `done_i`, all strobes are high, the flags and address return to zero, and `req_ready_o` is high.
- R11: At most one of the five strobes is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block can accept a request |
| laddr_i | input | 24 | Logical word address |
| acc_i | input | 2 | Access kind: 0 fetch, 1 program data, 2 data, 3 I/O |
| wide24_i | input | 1 | Logical width is 24 bit (0: 16 bit) |
| bus8_i | input | 1 | Physical bus is 8 bit (0: 16 bit) |
| dfmt24_i | input | 1 | Treat data accesses as 24 bit |
| bootovr_i | input | 3 | Boot-strobe override per kind |
| done_i | input | 1 | Current access finished |
| bank_stb_no | output | 4 | Active-low bank strobes |
| boot_stb_no | output | 1 | Active-low boot-memory strobe |
| paddr_o | output | 22 | Physical address |
| on_chip_o | output | 1 | Held access targets on-chip memory |
| boot_rom_o | output | 1 | Held access targets boot ROM page |
| off_chip_o | output | 1 | Held access goes off-chip |

## Verification
Every result of a request is registered once, so strobes, flags and address are due one clock after the accepting edge. Release is due one clock after the edge where `done_i` is high. The bench changes inputs on falling edges and samples on the next falling edge, which lies half a period after the register updates. It also checks one cycle later, with a competing request offered, that nothing has moved. Expected values come from an arithmetic model of pages, banks and scale factors. This model is swept over every kind, width, bus and override combination across boundary addresses.

// File: rtl/ext_xlate_pkg.sv
package ext_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_PMD   = 2'd1,
    ACC_DMD   = 2'd2,
    ACC_IO    = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic on_chip;
    logic boot_rom;
    logic off_chip;
  } region_t;
endpackage

// File: rtl/ext_region_decode.sv
module ext_region_decode
  import ext_xlate_pkg::*;
#(
  parameter int LADDR_W = 24,
  parameter int PAGE_OFS_W = 16,
  parameter int NBANK = 4,
  parameter logic [LADDR_W-1:0] OVR_LIMIT = 24'hEFFFFF
) (
  input  logic [LADDR_W-1:0] laddr,
  input  acc_kind_t          kind,
  input  logic [2:0]         ovr,
  output region_t            region,
  output logic [NBANK-1:0]   bank_sel,
  output logic               boot_sel
);
  localparam int PAGE_W = LADDR_W - PAGE_OFS_W;
  localparam int BSEL_W = $clog2(NBANK);
  localparam logic [PAGE_W-1:0] TOP_PAGE = '1;
  localparam logic [LADDR_W-1:0] OVR_BASE = LADDR_W'(1) << PAGE_OFS_W;

  logic [PAGE_W-1:0] page;
  logic [BSEL_W-1:0] bsel;
  logic kind_ovr, in_ovr_range;

  assign page = laddr[LADDR_W-1 -: PAGE_W];
  assign bsel = laddr[LADDR_W-1 -: BSEL_W];

  always_comb begin
    region = '0;
    if (kind != ACC_IO) begin
      if (page == '0)           region.on_chip  = 1'b1;
      else if (page == TOP_PAGE) region.boot_rom = 1'b1;
      else                      region.off_chip = 1'b1;
    end
  end

  always_comb begin
    unique case (kind)
      ACC_FETCH: kind_ovr = ovr[0];
      ACC_PMD:   kind_ovr = ovr[1];
      ACC_DMD:   kind_ovr = ovr[2];
      default:   kind_ovr = 1'b0;
    endcase
  end

  assign in_ovr_range = (laddr >= OVR_BASE) && (laddr <= OVR_LIMIT);
  assign boot_sel = region.off_chip && kind_ovr && in_ovr_range;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_sel[b] = region.off_chip && !boot_sel && (bsel == BSEL_W'(b));
  end
endmodule

// File: rtl/ext_addr_scale.sv
module ext_addr_scale
  import ext_xlate_pkg::*;
#(
  parameter int LADDR_W = 24,
  parameter int PADDR_W = 22
) (
  input  logic [LADDR_W-1:0] laddr,
  input  acc_kind_t          kind,
  input  logic               wide24,
  input  logic               bus8,
  input  logic               dfmt24,
  input  logic               enable,
  output logic [PADDR_W-1:0] paddr
);
  logic eff24;
  logic [1:0] shamt;

  // data moves may be promoted to the 24-bit factor; fetches never are
  assign eff24 = wide24 || (dfmt24 && (kind == ACC_PMD || kind == ACC_DMD));

  always_comb begin
    unique case ({bus8, eff24})
      2'b00:   shamt = 2'd0;
      2'b01:   shamt = 2'd1;
      2'b10:   shamt = 2'd1;
      default: shamt = 2'd2;
    endcase
  end

  assign paddr = enable ? PADDR_W'(laddr << shamt) : '0;
endmodule

// File: rtl/ext_strobe_hold.sv
module ext_strobe_hold
  import ext_xlate_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int PADDR_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               done,
  input  logic [NBANK-1:0]   bank_sel,
  input  logic               boot_sel,
  input  region_t            region_d,
  input  logic [PADDR_W-1:0] paddr_d,
  output logic               busy,
  output logic [NBANK-1:0]   bank_n,
  output logic               boot_n,
  output region_t            region_q,
  output logic [PADDR_W-1:0] paddr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bank_n   <= '1;
      boot_n   <= 1'b1;
      region_q <= '0;
      paddr_q  <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      bank_n   <= ~bank_sel;
      boot_n   <= ~boot_sel;
      region_q <= region_d;
      paddr_q  <= paddr_d;
    end else if (busy && done) begin
      busy     <= 1'b0;
      bank_n   <= '1;
      boot_n   <= 1'b1;
      region_q <= '0;
      paddr_q  <= '0;
    end
  end

  // R10: an access in flight keeps its strobes and address
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable({bank_n, boot_n, paddr_q, region_q}));

  // R10: release one cycle after done
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |=> (&bank_n) && boot_n && !busy);
endmodule

// File: rtl/ext_strobe_xlate.sv
module ext_strobe_xlate
  import ext_xlate_pkg::*;
#(
  parameter int LADDR_W = 24,
  parameter int PADDR_W = 22,
  parameter int NBANK = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic [1:0]         acc_i,
  input  logic               wide24_i,
  input  logic               bus8_i,
  input  logic               dfmt24_i,
  input  logic [2:0]         bootovr_i,
  input  logic               done_i,
  output logic [NBANK-1:0]   bank_stb_no,
  output logic               boot_stb_no,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               on_chip_o,
  output logic               boot_rom_o,
  output logic               off_chip_o
);
  acc_kind_t          kind;
  region_t            region_d, region_q;
  logic [NBANK-1:0]   bank_sel;
  logic               boot_sel, busy, load;
  logic [PADDR_W-1:0] paddr_d;

  assign kind        = acc_kind_t'(acc_i);
  assign req_ready_o = !busy;
  assign load        = req_valid_i && !busy;

  ext_region_decode #(.LADDR_W(LADDR_W), .NBANK(NBANK)) u_dec (
    .laddr(laddr_i), .kind(kind), .ovr(bootovr_i),
    .region(region_d), .bank_sel(bank_sel), .boot_sel(boot_sel)
  );

  ext_addr_scale #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_scale (
    .laddr(laddr_i), .kind(kind), .wide24(wide24_i), .bus8(bus8_i),
    .dfmt24(dfmt24_i), .enable(region_d.off_chip), .paddr(paddr_d)
  );

  ext_strobe_hold #(.NBANK(NBANK), .PADDR_W(PADDR_W)) u_hold (
    .clk(clk_i), .rst_n(rst_ni), .load(load), .done(done_i),
    .bank_sel(bank_sel), .boot_sel(boot_sel), .region_d(region_d),
    .paddr_d(paddr_d), .busy(busy), .bank_n(bank_stb_no),
    .boot_n(boot_stb_no), .region_q(region_q), .paddr_q(paddr_o)
  );

  assign on_chip_o  = region_q.on_chip;
  assign boot_rom_o = region_q.boot_rom;
  assign off_chip_o = region_q.off_chip;

  // R11: never two strobes at once
  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{boot_stb_no, bank_stb_no}));

  // R8 (and R1, R2): no off-chip region, no strobe
  p_quiet_unless_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_chip_o |-> (&bank_stb_no) && boot_stb_no);

  // R1 / R2: internal pages carry a zero address
  p_zero_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_chip_o || boot_rom_o) |-> paddr_o == '0);

  // R9: acceptance closes the handshake for the next cycle
  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R3: an off-chip access asserts exactly one strobe
  p_off_strobes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_chip_o |-> $countones(~{boot_stb_no, bank_stb_no}) == 1);
endmodule

// File: tb/ext_strobe_xlate_test.sv
module ext_strobe_xlate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, rdy, done = 1'b0;
  logic [23:0] la = '0;
  logic [1:0] kd = '0;
  logic w24 = 1'b0, b8 = 1'b0, df = 1'b0;
  logic [2:0] ov = '0;
  logic [3:0] bank_n;
  logic boot_n;
  logic [21:0] pa;
  logic fon, from, foff;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_strobe_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_ready_o(rdy),
    .laddr_i(la), .acc_i(kd), .wide24_i(w24), .bus8_i(b8), .dfmt24_i(df),
    .bootovr_i(ov), .done_i(done), .bank_stb_no(bank_n), .boot_stb_no(boot_n),
    .paddr_o(pa), .on_chip_o(fon), .boot_rom_o(from), .off_chip_o(foff)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (addr %h kind %0d w24 %0d b8 %0d df %0d ov %b)",
               tag, act, exp, la, kd, w24, b8, df, ov);
    end
  endtask

  // arithmetic model
  task automatic model(input logic [23:0] a, input logic [1:0] k, input logic w,
                       input logic b, input logic d, input logic [2:0] o,
                       output logic [4:0] stb, output logic [21:0] p,
                       output logic [2:0] fl);
    int pg, fac;
    logic e24;
    pg = int'(a) / 65536;
    stb = 5'h1F; p = '0; fl = 3'b000;
    if (k != 2'd3) begin
      if (pg == 0) fl = 3'b100;
      else if (pg == 255) fl = 3'b010;
      else begin
        fl = 3'b001;
        e24 = w | (d & (k == 2'd1 || k == 2'd2));
        fac = b ? (e24 ? 4 : 2) : (e24 ? 2 : 1);
        p = 22'((int'(a) * fac) % (1 << 22));
        if (o[k] && a >= 24'h010000 && a <= 24'hEFFFFF) stb[4] = 1'b0;
        else stb[int'(a) / 24'h400000] = 1'b0;
      end
    end
  endtask

  task automatic run(input logic [23:0] a, input logic [1:0] k, input logic w,
                     input logic b, input logic d, input logic [2:0] o);
    logic [4:0] es;
    logic [21:0] ep;
    logic [2:0] ef;
    model(a, k, w, b, d, o, es, ep, ef);
    @(negedge clk);
    la = a; kd = k; w24 = w; b8 = b; df = d; ov = o; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk("R3/R6/R11 strobes", {27'd0, boot_n, bank_n}, {27'd0, es});
    chk("R4/R5/R7 phys address", {10'd0, pa}, {10'd0, ep});
    chk("R1/R2/R8 region flags", {29'd0, fon, from, foff}, {29'd0, ef});
    chk("R9 ready low while held", {31'd0, rdy}, 32'd0);
    // competing request while busy must be ignored
    la = 24'h400000; kd = 2'd0; ov = 3'b000; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk("R9/R10 held despite new request", {5'd0, boot_n, bank_n, pa},
        {5'd0, es, ep});
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R10 released after done", {26'd0, rdy, boot_n, bank_n},
        {26'd0, 1'b1, 5'h1F});
  endtask

  logic [23:0] addrs [17] = '{24'h000000, 24'h00FFFF, 24'h010000, 24'h044000,
    24'h3FFFFF, 24'h400000, 24'h408000, 24'h40FFFF, 24'h7FFFFF, 24'h800000,
    24'hBFFFFF, 24'hC00000, 24'hEFFFFF, 24'hF00000, 24'hFEFFFF, 24'hFF0000,
    24'hFFFFFF};

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset strobes idle", {27'd0, boot_n, bank_n}, 32'h1F);
    chk("R9 reset ready", {31'd0, rdy}, 32'd1);
    chk("R8 reset address/flags", {7'd0, pa, fon, from, foff}, 32'd0);
    rst_n = 1'b1;

    // named translations
    run(24'h40FFFF, 2'd2, 1'b0, 1'b1, 1'b0, 3'b000);
    chk("R5 0x40FFFF 16b on 8b", {10'd0, pa}, 32'h0);
    run(24'h408000, 2'd0, 1'b1, 1'b1, 1'b0, 3'b000);
    run(24'h044000, 2'd2, 1'b0, 1'b1, 1'b0, 3'b000);

    // direct checks sampled during a held access
    @(negedge clk);
    la = 24'h408000; kd = 2'd0; w24 = 1'b1; b8 = 1'b1; df = 1'b0; ov = '0; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk("R5 0x408000 24b on 8b", {10'd0, pa}, 32'h020000);
    chk("R3 bank 1 strobe", {28'd0, bank_n}, 32'hD);
    done = 1'b1; @(negedge clk); done = 1'b0;

    la = 24'h40FFFF; kd = 2'd2; w24 = 1'b0; b8 = 1'b1; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk("R5 0x40FFFF 16b on 8b", {10'd0, pa}, 32'h01FFFE);
    done = 1'b1; @(negedge clk); done = 1'b0;

    la = 24'h044000; kd = 2'd2; w24 = 1'b0; b8 = 1'b1; df = 1'b1; ov = 3'b100; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk("R7 data promoted to factor 4", {10'd0, pa}, 32'h110000);
    chk("R6 data override to boot strobe", {27'd0, boot_n, bank_n}, 32'h0F);
    done = 1'b1; @(negedge clk); done = 1'b0;

    // sweep
    for (int k = 0; k < 4; k++)
      for (int cfg = 0; cfg < 8; cfg++)
        for (int o = 0; o < 8; o++)
          for (int i = 0; i < 17; i++)
            run(addrs[i], 2'(k), cfg[2], cfg[1], cfg[0], 3'(o));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule